// File: doc/BRIEF.md
# Double-Banked 8-Point FFT Engine

This block computes an 8-point complex discrete Fourier transform on a stream of frames. It has two identical sample banks, and each bank can read two entries and write two entries in the same cycle. One bank collects the next frame from the input stream. The other bank is transformed in place by a single pipelined butterfly and then drained to the output stream. Because of this, a new frame can arrive while the previous one is still being computed.

Arriving samples are stored at bit-reversed addresses. The three decimation-in-time stages therefore work in place, and results leave in natural bin order. Each stage halves its results, so the output equals the true transform divided by 8.

The banks exchange roles when two things are true: the collecting bank holds a full frame, and the computing side has drained its last result. The exchange is shown as a single-cycle pulse. Until it happens, the input stream is held off.

Top module: `fft8_pingpong`

## Requirements
- R1: After reset, `in_ready` is high, `out_valid` is low and `out_last` is low.
- R2: A bank accepts exactly 8 samples, one per cycle in which `in_valid` and `in_ready` are both high. Once the 8th sample is taken, `in_ready` stays low until the next bank exchange.
- R3: `bank_swap` pulses for one cycle when the collecting bank is full and the computing side is idle. `in_ready` is high again in the cycle after the pulse. If a full frame is waiting, the pulse falls in the same cycle as `out_last` of the previous frame.
- R4: A frame sent right after the first frame's exchange is fully accepted before the first frame's first result appears.
- R5: Each frame produces 8 results on consecutive cycles with `out_valid` high, in bin order 0 to 7. `out_last` is high only with bin 7. `out_valid` is low in the cycle after `out_last`.
- R6: Bin k equals (1/8)·Σ x[n]·e^(−j2πnk/8), each part within 3 LSB. Inputs are placed as `in_re` + j·`in_im`, in arrival order n = 0..7. For a lone sample at n = 0 the result is exact.
- R7: Inputs with parts inside ±2^14 produce results without wrap-around, still within the R6 tolerance.
- R8: Result frames leave in the same order as their input frames were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Collecting bank can take a sample |
| in_re | input | 16 | Input sample, real part (signed) |
| in_im | input | 16 | Input sample, imaginary part (signed) |
| out_valid | output | 1 | Result present |
| out_re | output | 16 | Result, real part (signed) |
| out_im | output | 16 | Result, imaginary part (signed) |
| out_last | output | 1 | Marks bin 7 of a frame |
| bank_swap | output | 1 | One-cycle pulse when the banks exchange roles |

## Verification
The transform is driven with several test frames:
- A lone sample at n = 0. Its flat, exact spectrum catches any arithmetic or scaling slip.
- A constant frame and a real alternating frame. These use only trivial twiddles and land in bins 0 and 4.
- Complex tones at bins 1 and 3. These separate bit-reversal and twiddle-sign errors, because a mirrored order or a conjugated factor moves the energy to bins 7 or 5.
- A near-full-scale constant and tone, for headroom.
- A ramp and a pseudo-random frame, to exercise mixed twiddles.

Two frames are also sent back to back. This proves that the second frame is accepted while the first is being computed, and shows where the exchange falls relative to the first frame's last result.

// File: rtl/fft8_pkg.sv
package fft8_pkg;

    localparam int DATA_W    = 16;
    localparam int TWID_W    = 16;
    localparam int TWID_FRAC = 14;
    localparam int NPTS      = 8;
    localparam int ADDR_W    = $clog2(NPTS);
    localparam int NSTAGE    = ADDR_W;
    localparam int NBFLY     = NPTS / 2;
    localparam int BFLY_W    = $clog2(NBFLY);
    localparam int STG_W     = $clog2(NSTAGE);
    localparam int TW_IDX_W  = ADDR_W - 1;
    localparam int BF_LAT    = 2;
    localparam int STEPS     = NBFLY + BF_LAT;
    localparam int STEP_W    = $clog2(STEPS);
    localparam int CNT_W     = ADDR_W + 1;

    localparam int TW_ONE = 1 << TWID_FRAC;
    localparam int TW_R45 = int'(0.7071067811865476 * real'(TW_ONE));

    typedef struct packed {
        logic signed [DATA_W-1:0] re;
        logic signed [DATA_W-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic signed [TWID_W-1:0] re;
        logic signed [TWID_W-1:0] im;
    } twid_t;

    typedef struct packed {
        logic [ADDR_W-1:0] top;
        logic [ADDR_W-1:0] bot;
    } pair_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CALC = 2'd1,
        PH_READ = 2'd2
    } phase_t;

    function automatic twid_t twiddle(input logic [TW_IDX_W-1:0] k);
        twid_t t;
        case (k)
            2'd0:    begin t.re = TWID_W'(TW_ONE);  t.im = '0;               end
            2'd1:    begin t.re = TWID_W'(TW_R45);  t.im = TWID_W'(-TW_R45); end
            2'd2:    begin t.re = '0;               t.im = TWID_W'(-TW_ONE); end
            default: begin t.re = TWID_W'(-TW_R45); t.im = TWID_W'(-TW_R45); end
        endcase
        return t;
    endfunction

    function automatic logic [ADDR_W-1:0] bitrev(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] r;
        for (int i = 0; i < ADDR_W; i++) r[i] = a[ADDR_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/fft8_bank.sv
module fft8_bank
    import fft8_pkg::*;
(
    input  logic              clk,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] waddr_a,
    input  cplx_t             wdata_a,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] waddr_b,
    input  cplx_t             wdata_b,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output cplx_t             rdata_a,
    output cplx_t             rdata_b
);

    cplx_t mem [NPTS];

    always_ff @(posedge clk) begin
        if (we_a) mem[waddr_a] <= wdata_a;
        if (we_b) mem[waddr_b] <= wdata_b;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/fft8_agu.sv
module fft8_agu
    import fft8_pkg::*;
(
    input  logic [STG_W-1:0]    stage,
    input  logic [BFLY_W-1:0]   idx,
    output pair_t               addr,
    output logic [TW_IDX_W-1:0] tw_idx
);

    logic [ADDR_W-1:0] idx_x;
    logic [ADDR_W-1:0] half_m;
    logic [ADDR_W-1:0] top_a;

    always_comb begin
        idx_x  = ADDR_W'(idx);
        half_m = ADDR_W'((1 << stage) - 1);
        top_a  = ADDR_W'(((idx_x >> stage) << (stage + 1)) | (idx_x & half_m));
        addr.top = top_a;
        addr.bot = top_a | (half_m + 1'b1);
        tw_idx   = TW_IDX_W'((idx_x & half_m) << (NSTAGE - 1 - stage));
    end

endmodule

// File: rtl/fft8_bfly.sv
module fft8_bfly
    import fft8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_vld,
    input  cplx_t a_i,
    input  cplx_t b_i,
    input  twid_t w_i,
    input  pair_t tag_i,
    output logic  out_vld,
    output cplx_t a_o,
    output cplx_t b_o,
    output pair_t tag_o
);

    localparam int PW = DATA_W + TWID_W + 1;
    localparam int SW = DATA_W + 2;
    localparam int SX = SW + 1;

    logic  vld_r;
    cplx_t a_r, b_r;
    twid_t w_r;
    pair_t tag_r;

    logic signed [PW-1:0] p_re, p_im;
    logic signed [SW-1:0] wb_re, wb_im;
    logic signed [SX-1:0] s_re, s_im, d_re, d_im;
    cplx_t                a_n, b_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_r   <= 1'b0;
            out_vld <= 1'b0;
        end else begin
            vld_r   <= in_vld;
            out_vld <= vld_r;
        end
    end

    always_ff @(posedge clk) begin
        a_r   <= a_i;
        b_r   <= b_i;
        w_r   <= w_i;
        tag_r <= tag_i;
        a_o   <= a_n;
        b_o   <= b_n;
        tag_o <= tag_r;
    end

    always_comb begin
        p_re  = PW'(b_r.re) * PW'(w_r.re) - PW'(b_r.im) * PW'(w_r.im);
        p_im  = PW'(b_r.re) * PW'(w_r.im) + PW'(b_r.im) * PW'(w_r.re);
        wb_re = SW'(p_re >>> TWID_FRAC);
        wb_im = SW'(p_im >>> TWID_FRAC);
        s_re  = SX'(a_r.re) + SX'(wb_re);
        s_im  = SX'(a_r.im) + SX'(wb_im);
        d_re  = SX'(a_r.re) - SX'(wb_re);
        d_im  = SX'(a_r.im) - SX'(wb_im);
        a_n.re = DATA_W'(s_re >>> 1);
        a_n.im = DATA_W'(s_im >>> 1);
        b_n.re = DATA_W'(d_re >>> 1);
        b_n.im = DATA_W'(d_im >>> 1);
    end

endmodule

// File: rtl/fft8_pingpong.sv
module fft8_pingpong
    import fft8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_re,
    input  logic [DATA_W-1:0] in_im,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_re,
    output logic [DATA_W-1:0] out_im,
    output logic              out_last,
    output logic              bank_swap
);

    localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(STEPS - 1);
    localparam logic [STEP_W-1:0] ISSUE_END  = STEP_W'(NBFLY);
    localparam logic [STG_W-1:0]  LAST_STAGE = STG_W'(NSTAGE - 1);
    localparam logic [CNT_W-1:0]  FULL_CNT   = CNT_W'(NPTS);
    localparam logic [ADDR_W-1:0] LAST_ADDR  = ADDR_W'(NPTS - 1);

    logic              fill_sel;
    logic [CNT_W-1:0]  fill_cnt;
    phase_t            phase;
    logic [STG_W-1:0]  stage;
    logic [STEP_W-1:0] step;
    logic [ADDR_W-1:0] rd_cnt;

    logic fill_full, proc_idle, accept, issue;

    pair_t               pair;
    logic [TW_IDX_W-1:0] tw_idx;
    cplx_t               smp;
    cplx_t               rd_a [2];
    cplx_t               rd_b [2];
    cplx_t               op_a, op_b;
    logic [ADDR_W-1:0]   proc_ra;

    logic  bf_vld;
    cplx_t bf_a, bf_b;
    pair_t bf_tag;

    assign fill_full = (fill_cnt == FULL_CNT);
    assign proc_idle = (phase == PH_IDLE);
    assign bank_swap = fill_full && proc_idle;
    assign in_ready  = !fill_full;
    assign accept    = in_valid && in_ready;
    assign issue     = (phase == PH_CALC) && (step < ISSUE_END);
    assign smp.re    = in_re;
    assign smp.im    = in_im;
    assign proc_ra   = (phase == PH_READ) ? rd_cnt : pair.top;
    assign op_a      = rd_a[!fill_sel];
    assign op_b      = rd_b[!fill_sel];

    // bank collection side
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_sel <= 1'b0;
            fill_cnt <= '0;
        end else if (bank_swap) begin
            fill_sel <= !fill_sel;
            fill_cnt <= '0;
        end else if (accept) begin
            fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // compute and drain sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            stage  <= '0;
            step   <= '0;
            rd_cnt <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (bank_swap) begin
                    phase <= PH_CALC;
                    stage <= '0;
                    step  <= '0;
                end
                PH_CALC: begin
                    if (step == LAST_STEP) begin
                        step <= '0;
                        if (stage == LAST_STAGE) begin
                            phase  <= PH_READ;
                            rd_cnt <= '0;
                        end else begin
                            stage <= stage + 1'b1;
                        end
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                PH_READ: begin
                    rd_cnt <= rd_cnt + 1'b1;
                    if (rd_cnt == LAST_ADDR) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    fft8_agu u_agu (
        .stage  (stage),
        .idx    (step[BFLY_W-1:0]),
        .addr   (pair),
        .tw_idx (tw_idx)
    );

    fft8_bfly u_bfly (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (issue),
        .a_i     (op_a),
        .b_i     (op_b),
        .w_i     (twiddle(tw_idx)),
        .tag_i   (pair),
        .out_vld (bf_vld),
        .a_o     (bf_a),
        .b_o     (bf_b),
        .tag_o   (bf_tag)
    );

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic is_fill;
        logic we_a, we_b;
        logic [ADDR_W-1:0] wa_a;
        cplx_t wd_a;

        assign is_fill = (fill_sel == 1'(g));
        assign we_a    = is_fill ? accept : bf_vld;
        assign wa_a    = is_fill ? bitrev(fill_cnt[ADDR_W-1:0]) : bf_tag.top;
        assign wd_a    = is_fill ? smp : bf_a;
        assign we_b    = !is_fill && bf_vld;

        fft8_bank u_bank (
            .clk     (clk),
            .we_a    (we_a),
            .waddr_a (wa_a),
            .wdata_a (wd_a),
            .we_b    (we_b),
            .waddr_b (bf_tag.bot),
            .wdata_b (bf_b),
            .raddr_a (proc_ra),
            .raddr_b (pair.bot),
            .rdata_a (rd_a[g]),
            .rdata_b (rd_b[g])
        );
    end

    // result stream
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= (phase == PH_READ);
            out_last  <= (phase == PH_READ) && (rd_cnt == LAST_ADDR);
            out_re    <= op_a.re;
            out_im    <= op_a.im;
        end
    end

endmodule

// File: rtl/fft8_pingpong_chk.sv
module fft8_pingpong_chk (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic out_valid,
    input logic out_last,
    input logic bank_swap
);

    // R5
    last_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R5
    gap_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |=> !out_valid);

    // R3
    swap_single_chk: assert property (@(posedge clk) disable iff (rst)
        bank_swap |=> !bank_swap);

    // R3
    ready_after_swap_chk: assert property (@(posedge clk) disable iff (rst)
        bank_swap |=> in_ready);

    // R2
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !bank_swap) |=> !in_ready);

endmodule

bind fft8_pingpong fft8_pingpong_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .bank_swap (bank_swap)
);

// File: tb/tb_fft8_pingpong.sv
module tb_fft8_pingpong;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_re = '0;
    logic [15:0] in_im = '0;
    logic        out_valid;
    logic [15:0] out_re, out_im;
    logic        out_last;
    logic        bank_swap;

    always #5 clk = ~clk;

    fft8_pingpong dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im),
        .out_last  (out_last),
        .bank_swap (bank_swap)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int first_out_cyc = -1;
    int bin_i  = 0;
    bit done   = 0;

    int exp_re_q[$];
    int exp_im_q[$];
    int tol_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: pushes expected bins, then streams the frame
    task automatic send_frame(input int xr[8], input int xi[8], input int tol);
        for (int k = 0; k < 8; k++) begin
            real sr = 0.0, si = 0.0;
            for (int n = 0; n < 8; n++) begin
                real th = 2.0 * 3.141592653589793 * real'(n * k) / 8.0;
                sr += real'(xr[n]) * $cos(th) + real'(xi[n]) * $sin(th);
                si += real'(xi[n]) * $cos(th) - real'(xr[n]) * $sin(th);
            end
            exp_re_q.push_back($rtoi(sr / 8.0 + (sr >= 0.0 ? 0.5 : -0.5)));
            exp_im_q.push_back($rtoi(si / 8.0 + (si >= 0.0 ? 0.5 : -0.5)));
            tol_q.push_back(tol);
        end
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_re = 16'(xr[n]);
            in_im = 16'(xi[n]);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            int ar, ai, er, ei, tl;
            ar = int'($signed(out_re));
            ai = int'($signed(out_im));
            if (first_out_cyc < 0) first_out_cyc = cyc;
            if (exp_re_q.size() == 0) begin
                check(1'b0, "R8 unexpected result", ar, 0);
            end else begin
                er = exp_re_q.pop_front();
                ei = exp_im_q.pop_front();
                tl = tol_q.pop_front();
                // R6 R7 R8: value and ordering
                check((ar - er <= tl) && (er - ar <= tl), "R6 real part", ar, er);
                check((ai - ei <= tl) && (ei - ai <= tl), "R6 imag part", ai, ei);
                // R5: last flag only on bin 7
                check(out_last == (bin_i == 7), "R5 last flag", int'(out_last), int'(bin_i == 7));
                bin_i = (bin_i + 1) % 8;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int xr[8], xi[8];
        int b_done;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(out_last == 1'b0, "R1 out_last after reset", int'(out_last), 0);

        // frame A: lone sample, exact result (R6)
        foreach (xr[n]) begin xr[n] = 0; xi[n] = 0; end
        xr[0] = 8000; xi[0] = -4000;
        send_frame(xr, xi, 0);

        // frame B: constant, sent during A's computation (R4)
        foreach (xr[n]) begin xr[n] = 1000; xi[n] = -200; end
        send_frame(xr, xi, 3);
        b_done = cyc;
        check(first_out_cyc < 0, "R4 next frame taken before first result", first_out_cyc, -1);
        // R2: bank full, held off
        check(in_ready == 1'b0, "R2 in_ready low after 8 samples", int'(in_ready), 0);
        while (!out_last) @(negedge clk);
        // R3: exchange falls on A's last result while B waits
        check(bank_swap == 1'b1, "R3 swap with out_last", int'(bank_swap), 1);
        check(in_ready == 1'b0, "R2 in_ready low until swap", int'(in_ready), 0);
        @(negedge clk);
        check(in_ready == 1'b1, "R3 in_ready after swap", int'(in_ready), 1);
        check(b_done < first_out_cyc, "R4 overlap timing", b_done, first_out_cyc);

        // real alternating -> bin 4
        foreach (xr[n]) begin xr[n] = (n % 2 == 0) ? 800 : -800; xi[n] = 0; end
        send_frame(xr, xi, 3);
        // complex tone at bin 1 (bit-reversal and twiddle sign)
        foreach (xr[n]) begin
            xr[n] = $rtoi(6000.0 * $cos(2.0 * 3.141592653589793 * n / 8.0));
            xi[n] = $rtoi(6000.0 * $sin(2.0 * 3.141592653589793 * n / 8.0));
        end
        send_frame(xr, xi, 3);
        // R7: near-full-scale constant
        foreach (xr[n]) begin xr[n] = 16383; xi[n] = -16384; end
        send_frame(xr, xi, 3);
        // R7: near-full-scale tone at bin 3
        foreach (xr[n]) begin
            xr[n] = $rtoi(16000.0 * $cos(2.0 * 3.141592653589793 * 3 * n / 8.0));
            xi[n] = $rtoi(16000.0 * $sin(2.0 * 3.141592653589793 * 3 * n / 8.0));
        end
        send_frame(xr, xi, 3);
        // ramp
        foreach (xr[n]) begin xr[n] = n * 1500 - 5000; xi[n] = 3000 - n * 700; end
        send_frame(xr, xi, 3);
        // pseudo-random
        begin
            int unsigned s = 32'h1234_5678;
            foreach (xr[n]) begin
                s = s * 1103515245 + 12345;
                xr[n] = int'((s >> 8) % 16001) - 8000;
                s = s * 1103515245 + 12345;
                xi[n] = int'((s >> 8) % 16001) - 8000;
            end
        end
        send_frame(xr, xi, 3);

        // drain the scoreboard
        for (int w = 0; w < 2000 && exp_re_q.size() != 0; w++) @(negedge clk);
        check(exp_re_q.size() == 0, "R8 all frames returned", exp_re_q.size(), 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule